// File: doc/BRIEF.md
# Three-Stage Pipelined Integer Core

This block is a small in-order integer core built as a three-stage pipeline. The first stage puts the program counter on an instruction-memory read port. The second stage takes the word that comes back one cycle later, decodes it and selects the register operands. The third stage computes the result, writes it to the register file in the same cycle, and reports the completed instruction on a retire port. A new instruction enters the pipeline every cycle, and there are no stalls.

The instruction set has four operations: an add of two registers, a load of a small immediate, an absolute jump and a no-op. Both pipeline conflicts are handled in hardware.

- When an instruction in the third stage writes a register that the instruction in the second stage reads, the new result is sent straight to that operand.
- A jump resolved in the third stage cancels the two younger instructions already in flight, and fetch restarts at the target on the next cycle.

The instruction-memory port has a fixed latency and no handshake: it must return the addressed word on the cycle after the address, and it cannot apply back-pressure. The retire port is a plain one-cycle strobe with no ready signal. It exists so that an external model can follow the architectural state.

Top module: `rc3_core`

## Requirements
- R1: While the synchronous reset is held (at least one clock edge after it is raised), `imem_addr` is 0, `ret_valid` is 0 and every register reads 0 on the debug port.
- R2: Instructions are 16 bits wide. Bits [15:12] select the operation: 0 is a no-op, 1 is ADD (rd [11:8], rs1 [7:4], rs2 [3:0]), 2 is JUMP (absolute target in [11:0]) and 3 is LOAD-IMMEDIATE (rd [11:8], zero-extended value [7:0]). Every other value behaves as a no-op: it retires with `ret_rd`=0 and `ret_value`=0 and writes nothing.
- R3: Without jumps, `imem_addr` rises by one each cycle. In the first cycle after reset it is 0, and in the second it is 1. The word for an address must arrive on the cycle after that address is presented. The instruction fetched in cycle 1 retires in cycle 3, and later instructions retire on consecutive cycles.
- R4: ADD writes rs1+rs2 modulo 2^16 to rd. LOAD-IMMEDIATE writes its value to rd. Each of them pulses `ret_valid` for one cycle with `ret_rd`=rd and `ret_value` equal to the written value. A no-op or a jump retires with `ret_rd`=0 and `ret_value`=0.
- R5: Register 0 always reads as 0, both as an operand and on the debug port. A write to it is discarded, although the retire port still reports rd=0 and the computed value.
- R6: If an instruction reads a register that the instruction immediately before it writes, it uses the new value, on either operand or on both. Forwarding takes priority over the register-file read. A register written two instructions earlier is read back already updated.
- R7: `dbg_data` shows the current contents of the register selected by `dbg_addr` in the same cycle, with no delay.
- R8: On the cycle after a jump retires, `imem_addr` equals the jump target. The two instructions that follow the jump in memory never retire and never change a register. The next retire comes exactly three cycles after the jump's retire. A jump placed at the target of another jump works the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | PC_W | Instruction fetch address (program counter) |
| imem_data | input | 16 | Instruction word for the previous cycle's address |
| dbg_addr | input | 4 | Debug register select |
| dbg_data | output | DATA_W | Contents of the selected register |
| ret_valid | output | 1 | One-cycle strobe per completed, non-cancelled instruction |
| ret_rd | output | 4 | Destination register of the completed instruction |
| ret_value | output | DATA_W | Value produced by the completed instruction |

## Verification
The bench targets these corner cases:

- **Back-to-back dependencies.** An add reads a register loaded by the instruction just before it, on one operand or on both. A design without the forwarding path would read the stale value, so `ret_value` would disagree.
- **Register 0.** A write to register 0 is followed at once by a read of register 0. A design that forwarded or stored that write would return the discarded sum instead of 0.
- **Jump shadows.** Loads sit in the two slots behind each jump, one jump is placed at the target of another, and register writes are later checked on the debug port. A design that cancelled only one slot, or restarted at the wrong address, would show an extra retire, a wrong gap after the jump, or a polluted register.
- **Other cases.** Unused operation codes and add overflow are included. A second reset follows a program that left registers non-zero, which exposes any register that reset fails to clear.

// File: rtl/rc3_pkg.sv
package rc3_pkg;
  localparam int INSN_W = 16;
  localparam int RA_W   = 4;
  localparam int IMM_W  = 8;
  localparam int TGT_W  = 12;

  typedef enum logic [1:0] {K_NOP, K_ADD, K_JMP, K_LDI} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [RA_W-1:0]   rd;
    logic [RA_W-1:0]   rs1;
    logic [RA_W-1:0]   rs2;
    logic [IMM_W-1:0]  imm;
    logic [TGT_W-1:0]  tgt;
  } dec_t;

  function automatic dec_t decode(input logic [INSN_W-1:0] w);
    dec_t d;
    d.rd  = w[11:8];
    d.rs1 = w[7:4];
    d.rs2 = w[3:0];
    d.imm = w[7:0];
    d.tgt = w[11:0];
    case (w[15:12])
      4'h1:    d.kind = K_ADD;
      4'h2:    d.kind = K_JMP;
      4'h3:    d.kind = K_LDI;
      default: d.kind = K_NOP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rc3_fetch.sv
module rc3_fetch #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output logic            slot_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      slot_valid <= 1'b0;
    end else if (redirect) begin
      pc         <= target;
      slot_valid <= 1'b0;
    end else begin
      pc         <= pc + PC_W'(1);
      slot_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/rc3_regfile.sv
module rc3_regfile #(
  parameter int DATA_W   = 16,
  parameter int RA_W     = 4,
  parameter int RD_PORTS = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [RA_W-1:0]                  waddr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [RD_PORTS-1:0][RA_W-1:0]    raddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdata
);
  localparam int NREG = 1 << RA_W;

  logic [NREG-1:0][DATA_W-1:0] file_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign file_q[i] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                q <= '0;
        else if (we && (waddr == RA_W'(i)))     q <= wdata;
      end
      assign file_q[i] = q;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rdata[p] = file_q[raddr[p]];
  end
endmodule

// File: rtl/rc3_fwd.sv
module rc3_fwd #(
  parameter int DATA_W = 16,
  parameter int RA_W   = 4
) (
  input  logic [RA_W-1:0]   rs,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              ex_we,
  input  logic [RA_W-1:0]   ex_rd,
  input  logic [DATA_W-1:0] ex_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    if (ex_we && (ex_rd == rs)) opnd = ex_val;
    else                        opnd = rf_val;
  end
endmodule

// File: rtl/rc3_exec.sv
module rc3_exec import rc3_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  kind_e             d_kind,
  input  logic [RA_W-1:0]   d_rd,
  input  logic [IMM_W-1:0]  d_imm,
  input  logic [TGT_W-1:0]  d_tgt,
  input  logic [DATA_W-1:0] d_a,
  input  logic [DATA_W-1:0] d_b,
  output logic              wr_en,
  output logic [RA_W-1:0]   wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              redirect,
  output logic [PC_W-1:0]   target,
  output logic              ret_valid,
  output logic [RA_W-1:0]   ret_rd,
  output logic [DATA_W-1:0] ret_value
);
  logic              ex_valid;
  kind_e             ex_kind;
  logic [RA_W-1:0]   ex_rd;
  logic [IMM_W-1:0]  ex_imm;
  logic [TGT_W-1:0]  ex_tgt;
  logic [DATA_W-1:0] ex_a, ex_b;
  logic [DATA_W-1:0] result;
  logic              writes_reg;

  always_ff @(posedge clk) begin
    if (rst || redirect) ex_valid <= 1'b0;
    else                 ex_valid <= d_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_kind <= K_NOP;
      ex_rd   <= '0;
      ex_imm  <= '0;
      ex_tgt  <= '0;
      ex_a    <= '0;
      ex_b    <= '0;
    end else begin
      ex_kind <= d_kind;
      ex_rd   <= d_rd;
      ex_imm  <= d_imm;
      ex_tgt  <= d_tgt;
      ex_a    <= d_a;
      ex_b    <= d_b;
    end
  end

  always_comb begin
    case (ex_kind)
      K_ADD:   result = ex_a + ex_b;
      K_LDI:   result = DATA_W'(ex_imm);
      default: result = '0;
    endcase
  end

  assign writes_reg = (ex_kind == K_ADD) || (ex_kind == K_LDI);
  assign wr_en      = ex_valid && writes_reg && (ex_rd != '0);
  assign wr_addr    = ex_rd;
  assign wr_data    = result;
  assign redirect   = ex_valid && (ex_kind == K_JMP);
  assign target     = PC_W'(ex_tgt);
  assign ret_valid  = ex_valid;
  assign ret_rd     = writes_reg ? ex_rd : '0;
  assign ret_value  = result;

  AST_SHADOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !ret_valid); // R8
  AST_SHADOW_SECOND: assert property (@(posedge clk) disable iff (rst)
    redirect |=> ##1 !ret_valid); // R8
endmodule

// File: rtl/rc3_core.sv
module rc3_core import rc3_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_data,
  input  logic [RA_W-1:0]   dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              ret_valid,
  output logic [RA_W-1:0]   ret_rd,
  output logic [DATA_W-1:0] ret_value
);
  localparam int NRD  = 3;
  localparam int NSRC = 2;

  dec_t dec;
  logic slot_valid, redirect, wr_en;
  logic [PC_W-1:0]   target;
  logic [RA_W-1:0]   wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [NRD-1:0][RA_W-1:0]    rf_addr;
  logic [NRD-1:0][DATA_W-1:0]  rf_data;
  logic [NSRC-1:0][RA_W-1:0]   src_idx;
  logic [NSRC-1:0][DATA_W-1:0] opnd;

  assign dec = decode(imem_data);

  rc3_fetch #(.PC_W(PC_W)) u_fetch (
    .clk(clk), .rst(rst), .redirect(redirect), .target(target),
    .pc(imem_addr), .slot_valid(slot_valid)
  );

  assign src_idx  = {dec.rs2, dec.rs1};
  assign rf_addr  = {dbg_addr, dec.rs2, dec.rs1};
  assign dbg_data = rf_data[2];

  rc3_regfile #(.DATA_W(DATA_W), .RA_W(RA_W), .RD_PORTS(NRD)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rf_addr), .rdata(rf_data)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rc3_fwd #(.DATA_W(DATA_W), .RA_W(RA_W)) u_fwd (
      .rs(src_idx[g]), .rf_val(rf_data[g]), .ex_we(wr_en),
      .ex_rd(wr_addr), .ex_val(wr_data), .opnd(opnd[g])
    );
  end

  rc3_exec #(.DATA_W(DATA_W), .PC_W(PC_W)) u_exec (
    .clk(clk), .rst(rst), .d_valid(slot_valid), .d_kind(dec.kind),
    .d_rd(dec.rd), .d_imm(dec.imm), .d_tgt(dec.tgt),
    .d_a(opnd[0]), .d_b(opnd[1]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .redirect(redirect), .target(target),
    .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_value(ret_value)
  );

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    redirect |=> imem_addr == $past(target)); // R8
  AST_RETIRE_FROM_FETCH: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(slot_valid)); // R3
endmodule

// File: tb/rc3_core_tb.sv
`timescale 1ns/1ps
module rc3_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] imem_addr;
  logic [15:0] imem_data = '0;
  logic [3:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  logic        ret_valid;
  logic [3:0]  ret_rd;
  logic [15:0] ret_value;

  always #4 clk = ~clk;

  rc3_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .ret_valid(ret_valid),
    .ret_rd(ret_rd), .ret_value(ret_value)
  );

  logic [15:0] mem [256];
  always @(posedge clk) imem_data <= mem[imem_addr[7:0]];

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] i_add(int rd, int a, int b);
    return {4'h1, 4'(rd), 4'(a), 4'(b)};
  endfunction
  function automatic logic [15:0] i_ldi(int rd, int v);
    return {4'h3, 4'(rd), 8'(v)};
  endfunction
  function automatic logic [15:0] i_jmp(int t);
    return {4'h2, 12'(t)};
  endfunction

  // behavioural reference model
  bit          mon_on = 0;
  int          cyc, last_ret, nret;
  bit          last_jmp, jchk;
  logic [11:0] mpc, jtgt;
  logic [15:0] mregs [16];
  logic [3:0]  prev_wr;

  function automatic logic [15:0] rr(logic [3:0] i);
    return (i == 0) ? 16'h0 : mregs[i];
  endfunction

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      logic [15:0] w, ev;
      logic [3:0]  erd;
      string       tag;
      int          expc;
      cyc++;
      if (cyc == 1) check("R3", "fetch addr cycle 1", imem_addr, 0);
      if (cyc == 2) check("R3", "fetch addr cycle 2", imem_addr, 1);
      if (jchk) begin
        check("R8", "fetch addr after jump", imem_addr, jtgt);
        jchk = 0;
      end
      if (ret_valid) begin
        w = mem[mpc[7:0]];
        expc = (nret == 0) ? 3 : last_ret + (last_jmp ? 3 : 1);
        check(last_jmp ? "R8" : "R3", "retire cycle", cyc, expc);
        erd = 0; ev = 0;
        case (w[15:12])
          4'h1: begin
            erd = w[11:8];
            ev  = rr(w[7:4]) + rr(w[3:0]);
            if (prev_wr != 0 && (w[7:4] == prev_wr || w[3:0] == prev_wr)) tag = "R6";
            else if (w[11:8] == 0 || w[7:4] == 0 || w[3:0] == 0)          tag = "R5";
            else                                                           tag = "R4";
          end
          4'h3: begin erd = w[11:8]; ev = {8'h0, w[7:0]}; tag = "R4"; end
          4'h2: tag = "R8";
          default: tag = "R2";
        endcase
        check(tag, "ret_rd", ret_rd, erd);
        check(tag, "ret_value", ret_value, ev);
        if ((w[15:12] == 4'h1 || w[15:12] == 4'h3) && erd != 0) begin
          mregs[erd] = ev;
          prev_wr = erd;
        end else prev_wr = 0;
        last_ret = cyc;
        last_jmp = (w[15:12] == 4'h2);
        nret++;
        if (last_jmp) begin
          mpc = w[11:0];
          jchk = 1;
          jtgt = w[11:0];
        end else mpc = mpc + 12'd1;
      end
    end
  end

  task automatic enter_reset();
    @(posedge clk); #2;
    rst = 1'b1;
    mon_on = 0;
    repeat (2) @(posedge clk);
    #2;
    check("R1", "imem_addr in reset", imem_addr, 0);
    check("R1", "ret_valid in reset", ret_valid, 0);
    for (int i = 0; i < 16; i++) begin
      dbg_addr = 4'(i);
      #0.2;
      check("R1", $sformatf("dbg R%0d in reset", i), dbg_data, 0);
    end
  endtask

  task automatic leave_reset();
    for (int i = 0; i < 16; i++) mregs[i] = '0;
    mpc = 0; cyc = 0; last_ret = 0; nret = 0;
    last_jmp = 0; jchk = 0; prev_wr = 0;
    @(posedge clk); #2;
    rst = 1'b0;
    mon_on = 1;
  endtask

  task automatic dbg_check();
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      dbg_addr = 4'(i);
      #2;
      check("R7", $sformatf("dbg R%0d", i), dbg_data, rr(4'(i)));
    end
  endtask

  initial begin
    int a;
    // program 1: forwarding, register 0, overflow, jump shadows
    enter_reset();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = i_ldi(1, 5);
    mem[1] = i_ldi(2, 7);
    mem[2] = i_add(3, 1, 2);
    mem[3] = i_add(4, 3, 3);
    mem[4] = i_add(5, 4, 1);
    mem[5] = i_add(0, 5, 5);
    mem[6] = i_add(6, 0, 5);
    mem[7] = i_ldi(7, 8'hFF);
    mem[8] = i_add(8, 7, 7);
    a = 9;
    for (int k = 0; k < 7; k++) begin mem[a] = i_add(8, 8, 8); a++; end
    mem[16] = i_add(9, 8, 8);
    mem[17] = i_jmp(20);
    mem[18] = i_ldi(10, 8'h33);
    mem[19] = i_ldi(11, 8'h44);
    mem[20] = i_add(12, 10, 1);
    mem[21] = i_jmp(21);
    leave_reset();
    repeat (60) @(posedge clk);
    dbg_check();
    check("R3", "retire count program 1 (min)", (nret >= 22), 1);
    check("R5", "R0 after write", rr(0), 0);

    // program 2: reset clears, unused codes, chained jumps
    enter_reset();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = i_ldi(2, 3);
    mem[1]  = 16'h0000;
    mem[2]  = 16'hF123;
    mem[3]  = i_jmp(6);
    mem[4]  = i_ldi(9, 9);
    mem[5]  = i_ldi(9, 9);
    mem[6]  = i_jmp(9);
    mem[7]  = i_ldi(9, 7);
    mem[8]  = i_add(2, 2, 2);
    mem[9]  = i_add(3, 2, 2);
    mem[10] = 16'h4321;
    mem[11] = i_add(4, 3, 3);
    mem[12] = i_jmp(12);
    leave_reset();
    repeat (50) @(posedge clk);
    dbg_check();
    check("R8", "retire count program 2 (min)", (nret >= 10), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule